// File: doc/BRIEF.md
# Scrypt Scratchpad Controller with Lookup Gap

This block runs the memory-hard middle of scrypt for a fixed cost parameter `N_ITER` (1024 by default). It takes a working state, builds a scratchpad by chaining an external block-mix engine `N_ITER` times, and then performs `N_ITER` data-dependent mixing rounds. Each round reads an entry back from the scratchpad, XORs it into the working state, and sends the result through the engine. The finished state is presented on `out_state`. The block-mix arithmetic itself is outside this block. The controller talks to the engine through a one-cycle `bm_start` with a full-width operand and waits for a one-cycle `bm_done` with the result.

The parameter `GAP` (1, 2 or 4) trades storage for engine work. Only every `GAP`-th chained state is written, so the scratchpad holds `N_ITER/GAP` entries. When a mixing round needs an entry that was not written, the controller fetches the closest stored entry at or below it. It then re-runs the engine on that entry until the missing one is rebuilt. Throughout this recompute the working state stays in its save register. A step counter on `steps` reports how many engine runs the current operation has issued.

Top module: `romix_sp_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `bm_start` are 0 and `steps` is 0.
- R2: A `start` seen while `busy` is 0 is accepted at that clock edge. `busy` is 1 from the next cycle, and `steps` restarts from 0.
- R3: A `start` seen while `busy` is 1 has no effect. The running result is unchanged, and no new operation begins after `done`.
- R4: The build phase issues `N_ITER` engine runs. The first run's operand equals the accepted `in_state`, and each later run's operand is the previous result.
- R5: The mixing index j of a round is the `log2(N_ITER)` low bits of the state starting at bit position `W/2`, which is the least significant word of the upper half.
- R6: During the build phase, chained state number i (the input counts as number 0) is stored only when i mod `GAP` is 0, in slot i/`GAP`. A mixing round reads slot j/`GAP` and runs the engine j mod `GAP` times on that entry before the XOR.
- R7: Each mixing round's final engine run takes the state XOR the rebuilt entry j. After `N_ITER` rounds, `out_state` equals the scrypt mixing result for that engine.
- R8: `steps` increments by one in the cycle after each `bm_start`. At the end it equals `N_ITER` plus the sum, over all rounds, of 1 + (j mod `GAP`).
- R9: `bm_start` lasts one cycle, occurs only while `busy`, and is never raised while an engine run is still outstanding.
- R10: `done` is a one-cycle pulse in the cycle where `busy` returns to 0. `out_state` changes only together with `done` and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation on `in_state` |
| in_state | input | W | Initial working state |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_state | output | W | Final state, held until the next completion |
| bm_start | output | 1 | Engine run request |
| bm_in | output | W | Engine operand, valid with `bm_start` |
| bm_done | input | 1 | Engine result strobe |
| bm_out | input | W | Engine result, valid with `bm_done` |
| steps | output | CNT_W | Engine runs issued by the current operation |

## Verification
The bench builds three copies side by side: `GAP`=4 with `N_ITER`=1024, `GAP`=2 with `N_ITER`=256, and `GAP`=1 with `N_ITER`=128. The `GAP`=4 copy covers the full default index width and recompute chains of length 0 to 3. The `GAP`=2 copy exercises the single-step recompute, and the `GAP`=1 copy exercises the direct-store path with its zero-width remainder. All three receive the same inputs, which include a start during busy. Each finishes at a different time, so completion and holding of the result are observed while the others are still running.

// File: rtl/romix_pkg.sv
package romix_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BUILD_GO,
        PH_BUILD_WAIT,
        PH_MIX_READ,
        PH_MIX_LOAD,
        PH_MIX_GO,
        PH_FIX_WAIT,
        PH_MIX_WAIT
    } phase_e;

endpackage

// File: rtl/romix_sp_ram.sv
module romix_sp_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int W     = 1024
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/romix_index.sv
module romix_index #(
    parameter int IDX_W  = 10,
    parameter int GAP    = 1,
    parameter int GAP_W  = 1,
    parameter int SLOT_W = 10
) (
    input  logic [IDX_W-1:0]  build_idx,
    input  logic [IDX_W-1:0]  mix_idx,
    output logic              wr_keep,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [GAP_W-1:0]  rd_rem
);
    generate
        if (GAP == 1) begin : g_full
            assign wr_keep = 1'b1;
            assign wr_slot = build_idx;
            assign rd_slot = mix_idx;
            assign rd_rem  = '0;
        end else begin : g_sparse
            assign wr_keep = (build_idx[GAP_W-1:0] == '0);
            assign wr_slot = build_idx[IDX_W-1:GAP_W];
            assign rd_slot = mix_idx[IDX_W-1:GAP_W];
            assign rd_rem  = mix_idx[GAP_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/romix_step_cnt.sv
module romix_step_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/romix_sp_ctrl.sv
module romix_sp_ctrl
    import romix_pkg::*;
#(
    parameter int N_ITER = 1024,
    parameter int GAP    = 1,
    parameter int W      = 1024,
    localparam int CNT_W = $clog2(N_ITER * (GAP + 1) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     in_state,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     out_state,
    output logic             bm_start,
    output logic [W-1:0]     bm_in,
    input  logic             bm_done,
    input  logic [W-1:0]     bm_out,
    output logic [CNT_W-1:0] steps
);
    localparam int IDX_W  = $clog2(N_ITER);
    localparam int GAP_W  = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int SLOTS  = N_ITER / GAP;
    localparam int SLOT_W = (GAP > 1) ? (IDX_W - GAP_W) : IDX_W;
    localparam int HALF   = W / 2;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ITER - 1);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] iter;
        logic [GAP_W-1:0] rem;
        logic [W-1:0]     x;
        logic [W-1:0]     t;
        logic [W-1:0]     res;
        logic             fin;
    } regs_t;

    regs_t r_q, r_d;

    logic              wr_keep;
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [GAP_W-1:0]  rd_rem;
    logic [IDX_W-1:0]  mix_idx;
    logic              ram_we, ram_re;
    logic [W-1:0]      ram_q;
    logic              cnt_clr;

    assign mix_idx = r_q.x[HALF +: IDX_W];

    romix_index #(
        .IDX_W (IDX_W),
        .GAP   (GAP),
        .GAP_W (GAP_W),
        .SLOT_W(SLOT_W)
    ) u_index (
        .build_idx(r_q.iter),
        .mix_idx  (mix_idx),
        .wr_keep  (wr_keep),
        .wr_slot  (wr_slot),
        .rd_slot  (rd_slot),
        .rd_rem   (rd_rem)
    );

    romix_sp_ram #(
        .DEPTH(SLOTS),
        .AW   (SLOT_W),
        .W    (W)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(wr_slot),
        .wdata(r_q.x),
        .re   (ram_re),
        .raddr(rd_slot),
        .rdata(ram_q)
    );

    romix_step_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (bm_start),
        .count(steps)
    );

    always_comb begin
        r_d      = r_q;
        r_d.fin  = 1'b0;
        ram_we   = 1'b0;
        ram_re   = 1'b0;
        cnt_clr  = 1'b0;
        bm_start = 1'b0;
        bm_in    = r_q.x;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.x    = in_state;
                    r_d.iter = '0;
                    r_d.ph   = PH_BUILD_GO;
                    cnt_clr  = 1'b1;
                end
            end
            PH_BUILD_GO: begin
                ram_we   = wr_keep;
                bm_start = 1'b1;
                bm_in    = r_q.x;
                r_d.ph   = PH_BUILD_WAIT;
            end
            PH_BUILD_WAIT: begin
                if (bm_done) begin
                    r_d.x = bm_out;
                    if (r_q.iter == LAST) begin
                        r_d.iter = '0;
                        r_d.ph   = PH_MIX_READ;
                    end else begin
                        r_d.iter = r_q.iter + IDX_W'(1);
                        r_d.ph   = PH_BUILD_GO;
                    end
                end
            end
            PH_MIX_READ: begin
                ram_re  = 1'b1;
                r_d.rem = rd_rem;
                r_d.ph  = PH_MIX_LOAD;
            end
            PH_MIX_LOAD: begin
                r_d.t  = ram_q;
                r_d.ph = PH_MIX_GO;
            end
            PH_MIX_GO: begin
                bm_start = 1'b1;
                if (r_q.rem != '0) begin
                    bm_in  = r_q.t;
                    r_d.ph = PH_FIX_WAIT;
                end else begin
                    bm_in  = r_q.x ^ r_q.t;
                    r_d.ph = PH_MIX_WAIT;
                end
            end
            PH_FIX_WAIT: begin
                if (bm_done) begin
                    r_d.t   = bm_out;
                    r_d.rem = r_q.rem - GAP_W'(1);
                    r_d.ph  = PH_MIX_GO;
                end
            end
            PH_MIX_WAIT: begin
                if (bm_done) begin
                    r_d.x = bm_out;
                    if (r_q.iter == LAST) begin
                        r_d.res = bm_out;
                        r_d.fin = 1'b1;
                        r_d.ph  = PH_IDLE;
                    end else begin
                        r_d.iter = r_q.iter + IDX_W'(1);
                        r_d.ph   = PH_MIX_READ;
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.ph != PH_IDLE);
    assign done      = r_q.fin;
    assign out_state = r_q.res;
endmodule

// File: rtl/romix_sp_ctrl_chk.sv
module romix_sp_ctrl_chk #(
    parameter int W     = 1024,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [W-1:0]     out_state,
    input logic             bm_start,
    input logic             bm_done,
    input logic [CNT_W-1:0] steps
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (bm_start) begin
            pend_q <= 1'b1;
        end else if (bm_done) begin
            pend_q <= 1'b0;
        end
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r2_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (steps == '0));
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bm_start |=> (steps == $past(steps) + CNT_W'(1)));
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bm_start |=> !bm_start);
    a_r9_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bm_start |-> busy);
    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        bm_start |-> !pend_q);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(out_state));
endmodule

bind romix_sp_ctrl romix_sp_ctrl_chk #(
    .W    (W),
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .out_state(out_state),
    .bm_start (bm_start),
    .bm_done  (bm_done),
    .steps    (steps)
);

// File: tb/romix_sp_ctrl_tb.sv
package romix_tb_pkg;
    function automatic logic [1023:0] mixfn(input logic [1023:0] x);
        logic [1023:0] y;
        y = {x[990:0], x[1023:991]};
        for (int k = 0; k < 32; k++) begin
            y[32*k +: 32] = y[32*k +: 32]
                + (x[32*((k + 5) % 32) +: 32] ^ (32'h9E3779B9 * 32'(k + 1)));
        end
        return y;
    endfunction
endpackage

module romix_bm_model #(
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [1023:0] din,
    output logic          fin,
    output logic [1023:0] dout
);
    int cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= 0;
            fin  <= 1'b0;
            dout <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                dout <= romix_tb_pkg::mixfn(din);
                cnt  <= LAT;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) fin <= 1'b1;
            end
        end
    end
endmodule

module romix_sp_ctrl_tb;
    import romix_tb_pkg::*;

    localparam int NC = 3;
    localparam int NV[NC] = '{1024, 256, 128};
    localparam int GV[NC] = '{4, 2, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1023:0] in_state = '0;

    logic          busy_a[NC], done_a[NC], bms_a[NC], bmd_a[NC];
    logic [1023:0] out_a[NC], bmi_a[NC], bmo_a[NC];
    logic [12:0]   st0;
    logic [9:0]    st1;
    logic [8:0]    st2;
    int            steps_i[NC];

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int            my_cnt[NC];
    bit            first[NC];
    logic [1023:0] acc[NC];
    bit            got[NC];
    logic [1023:0] got_out[NC];
    logic [1023:0] ref_out[NC];
    int            ref_steps[NC];

    always #5 clk = ~clk;

    assign steps_i[0] = int'(st0);
    assign steps_i[1] = int'(st1);
    assign steps_i[2] = int'(st2);

    romix_sp_ctrl #(.N_ITER(1024), .GAP(4), .W(1024)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_state(in_state),
        .busy(busy_a[0]), .done(done_a[0]), .out_state(out_a[0]),
        .bm_start(bms_a[0]), .bm_in(bmi_a[0]), .bm_done(bmd_a[0]),
        .bm_out(bmo_a[0]), .steps(st0));
    romix_sp_ctrl #(.N_ITER(256), .GAP(2), .W(1024)) u_dut_g2 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_state(in_state),
        .busy(busy_a[1]), .done(done_a[1]), .out_state(out_a[1]),
        .bm_start(bms_a[1]), .bm_in(bmi_a[1]), .bm_done(bmd_a[1]),
        .bm_out(bmo_a[1]), .steps(st1));
    romix_sp_ctrl #(.N_ITER(128), .GAP(1), .W(1024)) u_dut_g1 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_state(in_state),
        .busy(busy_a[2]), .done(done_a[2]), .out_state(out_a[2]),
        .bm_start(bms_a[2]), .bm_in(bmi_a[2]), .bm_done(bmd_a[2]),
        .bm_out(bmo_a[2]), .steps(st2));

    romix_bm_model #(.LAT(2)) u_bm0 (.clk(clk), .rst_n(rst_n), .go(bms_a[0]),
        .din(bmi_a[0]), .fin(bmd_a[0]), .dout(bmo_a[0]));
    romix_bm_model #(.LAT(3)) u_bm1 (.clk(clk), .rst_n(rst_n), .go(bms_a[1]),
        .din(bmi_a[1]), .fin(bmd_a[1]), .dout(bmo_a[1]));
    romix_bm_model #(.LAT(1)) u_bm2 (.clk(clk), .rst_n(rst_n), .go(bms_a[2]),
        .din(bmi_a[2]), .fin(bmd_a[2]), .dout(bmo_a[2]));

    task automatic check(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Behavioural reference: full table, chain then data-dependent mixing.
    task automatic ref_run(input logic [1023:0] x_in, input int n, input int g,
                           output logic [1023:0] x_out, output int cnt);
        logic [1023:0] v[];
        logic [1023:0] x;
        int j;
        v = new[n];
        x = x_in;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            v[i] = x;
            x = mixfn(x);
            cnt++;
        end
        for (int i = 0; i < n; i++) begin
            j = int'(x[512 +: 16]) % n;   // R5 index source
            cnt += 1 + (j % g);
            x = mixfn(x ^ v[j]);
        end
        x_out = x;
    endtask

    // Per-clock model of the step counter, operand of the first run and done.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int k = 0; k < NC; k++) begin
                check(steps_i[k] == my_cnt[k], "R8",
                      $sformatf("dut%0d steps=%0d expected %0d", k, steps_i[k], my_cnt[k]));
                if (done_a[k]) begin
                    got[k] = 1'b1;
                    got_out[k] = out_a[k];
                    check(!busy_a[k], "R10",
                          $sformatf("dut%0d busy=%0b expected 0 with done", k, busy_a[k]));
                end
                if (start && !busy_a[k]) begin
                    my_cnt[k] = 0;
                    first[k] = 1'b1;
                    acc[k] = in_state;
                end else if (bms_a[k]) begin
                    if (first[k]) begin
                        check(bmi_a[k] == acc[k], "R4",
                              $sformatf("dut%0d first operand %h expected %h", k, bmi_a[k], acc[k]));
                        first[k] = 1'b0;
                    end
                    my_cnt[k]++;
                end
            end
        end
    end

    task automatic do_run(input logic [1023:0] vec, input bit intr);
        for (int k = 0; k < NC; k++) begin
            ref_run(vec, NV[k], GV[k], ref_out[k], ref_steps[k]);
            got[k] = 1'b0;
        end
        @(posedge clk); #1;
        start = 1'b1;
        in_state = vec;
        @(posedge clk); #1;
        start = 1'b0;
        in_state = ~vec;
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check(busy_a[k] == 1'b1, "R2",
                  $sformatf("dut%0d busy=%0b expected 1 after start", k, busy_a[k]));
        end
        if (intr) begin
            repeat (40) @(posedge clk);
            #1;
            start = 1'b1;
            in_state = vec ^ {32{32'h5A5AC3C3}};
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (!(got[0] && got[1] && got[2])) @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check(got_out[k] == ref_out[k], intr ? "R3" : "R7",
                  $sformatf("dut%0d out %h expected %h", k, got_out[k], ref_out[k]));
            check(steps_i[k] == ref_steps[k], "R6",
                  $sformatf("dut%0d final steps=%0d expected %0d", k, steps_i[k], ref_steps[k]));
        end
        repeat (5) @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check(out_a[k] == ref_out[k], "R10",
                  $sformatf("dut%0d held out %h expected %h", k, out_a[k], ref_out[k]));
            check(busy_a[k] == 1'b0, "R3",
                  $sformatf("dut%0d busy=%0b expected 0 after completion", k, busy_a[k]));
        end
    endtask

    initial begin
        logic [1023:0] v;
        for (int k = 0; k < NC; k++) begin
            my_cnt[k] = 0;
            first[k] = 1'b0;
            got[k] = 1'b0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NC; k++) begin
            check(busy_a[k] == 1'b0 && done_a[k] == 1'b0 && bms_a[k] == 1'b0, "R1",
                  $sformatf("dut%0d busy/done/bm_start=%0b%0b%0b expected 000",
                            k, busy_a[k], done_a[k], bms_a[k]));
            check(steps_i[k] == 0, "R1",
                  $sformatf("dut%0d steps=%0d expected 0", k, steps_i[k]));
        end
        for (int w = 0; w < 32; w++) v[32*w +: 32] = 32'hDEADBEEF ^ 32'(w * 7);
        do_run(v, 1'b0);
        do_run('0, 1'b0);
        for (int w = 0; w < 32; w++) v[32*w +: 32] = 32'h1 << (w % 32);
        do_run(v, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run incomplete, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule